// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block sits between an on-chip request port and an external asynchronous static RAM of 262,144 words by 4 bits. It accepts one read or one write per transaction. It then walks the RAM's active-low chip-select, write-strobe and output-gate lines through a fixed order that is counted in system-clock cycles. The order meets the RAM's minimum pulse and access windows and keeps the shared data bus free of contention.

The requester presents an address, write data and a direction flag, and raises `req` while `ready` is high. The read result comes back on `rdData` together with a one-cycle `rdValid` strobe. On the pin side the shared bus is split into an outgoing value `memDout`, a drive enable `memDoe` for the pad's tri-state buffer, and the incoming value `memDin`. Three parameters convert the RAM's nanosecond limits to clock cycles, rounded up: `READ_CYC`, `WRITE_PULSE_CYC` and `TURN_CYC`.

Top module: `asram_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `memCeN`, `memWeN` and `memOeN` are 1, `memDoe` is 0, `rdValid` is 0 and `ready` is 1.
- R2: `ready` is 1 only when no transaction is in progress. Whenever `ready` is 1, `memCeN` is 1 (standby), `memWeN` and `memOeN` are 1 and `memDoe` is 0.
- R3: A transaction is accepted on a rising clock edge where `req` and `ready` are both 1, and `ready` is 0 in the following cycle. A `req` raised while `ready` is 0 is ignored and leaves the RAM contents untouched.
- R4: A write (`isWrite`=1) first spends one cycle with the address valid, `memCeN`=0 and `memOeN`=1 before `memWeN` falls.
- R5: `memDoe` rises exactly one cycle after `memWeN` falls. It is never 1 while `memOeN` is 0 or `memCeN` is 1.
- R6: `memWeN` stays low for WRITE_PULSE_CYC+1 cycles. Write data is driven for the last WRITE_PULSE_CYC of them.
- R7: `memDoe` stays 1, and address and `memCeN`=0 are held, for one cycle after `memWeN` rises. The drivers then turn off.
- R8: A read (`isWrite`=0) holds `memCeN`=0, `memOeN`=0 and `memWeN`=1 for READ_CYC cycles. `memDin` is registered on the last of those cycles. `rdValid` is 1 for exactly one cycle, READ_CYC cycles after acceptance, and `rdData` keeps that value afterwards.
- R9: After a read, `memOeN` is 1 for TURN_CYC cycles before `ready` returns. `ready` returns READ_CYC+TURN_CYC cycles after acceptance.
- R10: `ready` returns WRITE_PULSE_CYC+3 cycles after a write is accepted. Data written to an address is returned by any later read of that address.
- R11: `memAddr` does not change while `memCeN` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transaction request |
| isWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 4 | Write data |
| ready | output | 1 | Controller idle, request may be accepted |
| rdData | output | 4 | Last read result |
| rdValid | output | 1 | One-cycle strobe: `rdData` updated |
| memAddr | output | 18 | RAM address pins |
| memCeN | output | 1 | RAM chip select, active low |
| memWeN | output | 1 | RAM write strobe, active low |
| memOeN | output | 1 | RAM output gate, active low |
| memDout | output | 4 | Value driven onto the shared data bus |
| memDoe | output | 1 | Drive enable for the data bus pads |
| memDin | input | 4 | Value sampled from the shared data bus |

## Verification
The assertions take for granted that `req` is sampled only on clock edges and that the RAM places valid data on `memDin` within the READ_CYC window. They also assume `memDin` does not change in the capture cycle of a read. The bench drives every request at the falling edge. Its RAM model puts stored data on `memDin` combinationally as soon as the select and gate lines call for it. The same model measures the write strobe width and the data setup time in nanoseconds, and flags any cycle in which both sides drive the bus.

// File: rtl/asram_pkg.sv
package asram_pkg;
  // Strobes from the sequencer to the datapath and pins
  typedef struct packed {
    logic loadReq;  // latch address, data and direction
    logic capture;  // register the RAM's read data
    logic ceN;
    logic weN;
    logic oeN;
    logic drive;    // enable data bus drivers
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WLOW, S_WDRV, S_WREL, S_RACC, S_RTURN
  } state_t;
endpackage

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int READ_CYC        = 2,
  parameter int WRITE_PULSE_CYC = 1,
  parameter int TURN_CYC        = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  logic    isWrite,
  output logic    ready,
  output strobe_t strb
);
  localparam int MAX_CYC = (READ_CYC > WRITE_PULSE_CYC) ?
                           ((READ_CYC > TURN_CYC) ? READ_CYC : TURN_CYC) :
                           ((WRITE_PULSE_CYC > TURN_CYC) ? WRITE_PULSE_CYC : TURN_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WRITE_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] TN_LOAD = CNT_W'(TURN_CYC - 1);

  state_t stateQ;
  logic [CNT_W-1:0] cntQ;
  logic cntDone;

  assign cntDone = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= S_IDLE;
      cntQ   <= '0;
    end else begin
      case (stateQ)
        S_IDLE: if (req) begin
          stateQ <= isWrite ? S_WSET : S_RACC;
          cntQ   <= isWrite ? '0 : RD_LOAD;
        end
        S_WSET: stateQ <= S_WLOW;
        S_WLOW: begin
          stateQ <= S_WDRV;
          cntQ   <= WP_LOAD;
        end
        S_WDRV: if (cntDone) stateQ <= S_WREL; else cntQ <= cntQ - 1'b1;
        S_WREL: stateQ <= S_IDLE;
        S_RACC: if (cntDone) begin
          stateQ <= S_RTURN;
          cntQ   <= TN_LOAD;
        end else cntQ <= cntQ - 1'b1;
        S_RTURN: if (cntDone) stateQ <= S_IDLE; else cntQ <= cntQ - 1'b1;
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ready        = (stateQ == S_IDLE);
    strb.loadReq = ready && req;
    strb.capture = (stateQ == S_RACC) && cntDone;
    strb.ceN     = (stateQ == S_IDLE);
    strb.weN     = !((stateQ == S_WLOW) || (stateQ == S_WDRV));
    strb.oeN     = (stateQ != S_RACC);
    strb.drive   = (stateQ == S_WDRV) || (stateQ == S_WREL);
  end

  // Width of the write strobe, kept only for the pulse check below
  logic [CNT_W+1:0] weLowQ;
  always_ff @(posedge clk) begin
    if (rst || strb.weN) weLowQ <= '0;
    else if (weLowQ != '1) weLowQ <= weLowQ + 1'b1;
  end

  assert_ready_standby_R2: assert property (@(posedge clk) disable iff (rst)
    ready |-> strb.ceN && strb.weN && strb.oeN && !strb.drive);
  assert_we_setup_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(strb.weN) |-> $past(!strb.ceN) && $past(strb.oeN));
  assert_drive_oe_off_R5: assert property (@(posedge clk) disable iff (rst)
    strb.drive |-> strb.oeN && !strb.ceN);
  assert_drive_after_we_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(strb.drive) |-> !strb.weN && $past(!strb.weN));
  assert_we_width_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(strb.weN) |-> $past(weLowQ) >= (CNT_W+2)'(WRITE_PULSE_CYC));
  assert_we_release_held_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(strb.weN) |-> strb.drive && !strb.ceN);
  assert_read_lines_R8: assert property (@(posedge clk) disable iff (rst)
    !strb.oeN |-> strb.weN && !strb.ceN && !strb.drive);
endmodule

// File: rtl/asram_dpath.sv
module asram_dpath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              validQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      validQ <= 1'b0;
    end else begin
      if (strb.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdataQ <= memDin;
      validQ <= strb.capture;
    end
  end

  assign memAddr = addrQ;
  assign memDout = wdataQ;
  assign rdData  = rdataQ;
  assign rdValid = validQ;

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (!strb.ceN && $past(!strb.ceN)) |-> $stable(addrQ));
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    validQ |=> !validQ);
endmodule

// File: rtl/asram_port.sv
module asram_port
  import asram_pkg::*;
#(
  parameter int ADDR_W          = 18,
  parameter int DATA_W          = 4,
  parameter int READ_CYC        = 2,
  parameter int WRITE_PULSE_CYC = 1,
  parameter int TURN_CYC        = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  input  logic [DATA_W-1:0] memDin
);
  strobe_t strb;

  asram_ctrl #(
    .READ_CYC(READ_CYC), .WRITE_PULSE_CYC(WRITE_PULSE_CYC), .TURN_CYC(TURN_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req(req), .isWrite(isWrite),
    .ready(ready), .strb(strb)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memDin(memDin),
    .memAddr(memAddr), .memDout(memDout), .rdData(rdData), .rdValid(rdValid)
  );

  assign memCeN = strb.ceN;
  assign memWeN = strb.weN;
  assign memOeN = strb.oeN;
  assign memDoe = strb.drive;
endmodule

// File: tb/asram_port_bench.sv
module asram_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RD_C = 2;
  localparam int WP_C = 1;
  localparam int TN_C = 1;
  localparam int WE_MIN_NS = 10;
  localparam int DSET_MIN_NS = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, isWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [3:0] reqWdata = '0;
  logic ready, rdValid, memCeN, memWeN, memOeN, memDoe;
  logic [3:0] rdData, memDout, memDin;
  logic [17:0] memAddr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_port #(.READ_CYC(RD_C), .WRITE_PULSE_CYC(WP_C), .TURN_CYC(TURN_CYC_FIX)) u_asram_port (
    .clk(clk), .rst(rst), .req(req), .isWrite(isWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .ready(ready), .rdData(rdData), .rdValid(rdValid),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memDout(memDout), .memDoe(memDoe), .memDin(memDin)
  );
  localparam int TURN_CYC_FIX = TN_C;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural RAM
  logic [3:0] ramQ [int];
  logic [3:0] shadow [int];

  function automatic logic [3:0] ramRd(input logic [17:0] a);
    return ramQ.exists(int'(a)) ? ramQ[int'(a)] : 4'h0;
  endfunction

  assign memDin = (!memCeN && memWeN && !memOeN) ? ramRd(memAddr) : 4'h0;

  int weLow = 0;
  int drvLen = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (memDoe && !memCeN && memWeN && !memOeN)
        check(1'b0, "R5 bus contention", 1, 0);
      if (!memWeN) begin
        weLow++;
        if (memDoe) drvLen++;
      end else if (weLow != 0) begin
        check(weLow * CLK_PERIOD >= WE_MIN_NS, "R6 write strobe width ns", weLow * CLK_PERIOD, WE_MIN_NS);
        check(drvLen * CLK_PERIOD >= DSET_MIN_NS, "R6 data setup ns", drvLen * CLK_PERIOD, DSET_MIN_NS);
        check(memDoe && !memCeN, "R7 data held at strobe release", int'(memDoe), 1);
        ramQ[int'(memAddr)] = memDout;
        weLow = 0;
        drvLen = 0;
      end
    end
  end

  function automatic logic [3:0] expRd(input logic [17:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0;
  endfunction

  task automatic doWrite(input logic [17:0] a, input logic [3:0] d, input bit intrude);
    int n;
    @(negedge clk);
    check(ready, "R2 ready before write", int'(ready), 1);
    req = 1'b1; isWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    req = 1'b0;
    check(!ready, "R3 ready drops after accept", int'(ready), 0);
    if (intrude) begin
      req = 1'b1; isWrite = 1'b1; reqAddr = a ^ 18'h00001; reqWdata = ~d;
    end
    n = 0;
    while (!ready && n < 50) begin
      @(negedge clk);
      req = 1'b0;
      n++;
    end
    check(n == WP_C + 3, "R10 write latency", n, WP_C + 3);
    check(memCeN && memWeN && memOeN && !memDoe, "R2 standby when idle", int'(memCeN), 1);
    shadow[int'(a)] = d;
  endtask

  task automatic doRead(input logic [17:0] a);
    int n, vcnt, vN;
    logic [3:0] vD;
    @(negedge clk);
    req = 1'b1; isWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    req = 1'b0;
    check(!ready, "R3 ready drops after read accept", int'(ready), 0);
    n = 0; vcnt = 0; vN = -1; vD = '0;
    forever begin
      if (rdValid) begin vcnt++; vN = n; vD = rdData; end
      if (ready || n >= 50) break;
      if (n < RD_C && !(memOeN == 1'b0 && memWeN && !memCeN))
        check(1'b0, "R8 read lines", int'(memOeN), 0);
      if (n >= RD_C && !memOeN)
        check(1'b0, "R9 output gate off in turnaround", int'(memOeN), 1);
      @(negedge clk);
      n++;
    end
    check(n == RD_C + TN_C, "R9 read latency", n, RD_C + TN_C);
    check(vcnt == 1, "R8 single valid strobe", vcnt, 1);
    check(vN == RD_C, "R8 valid timing", vN, RD_C);
    check(vD == expRd(a), "R8 R10 read data", int'(vD), int'(expRd(a)));
    @(negedge clk);
    check(rdData == vD, "R8 rdData holds", int'(rdData), int'(vD));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(memCeN && memWeN && memOeN && !memDoe && !rdValid && ready,
          "R1 state in reset", int'(memCeN), 1);
    rst = 1'b0;
    @(negedge clk);
    check(memCeN && memWeN && memOeN && !memDoe && !rdValid && ready,
          "R1 state after reset", int'(ready), 1);

    // Read of unwritten location, then boundaries
    doRead(18'h00000);
    doWrite(18'h00000, 4'h9, 1'b0);
    doWrite(18'h3FFFF, 4'h6, 1'b0);
    doRead(18'h3FFFF);
    doRead(18'h00000);

    // Every data value at spread addresses
    for (int d = 0; d < 16; d++)
      doWrite(18'((d * 16411 + 7) & 18'h3FFFF), 4'(d), 1'b0);
    for (int d = 15; d >= 0; d--)
      doRead(18'((d * 16411 + 7) & 18'h3FFFF));

    // R3: request raised while busy is ignored
    doWrite(18'h12344, 4'hA, 1'b0);
    doWrite(18'h12345, 4'h3, 1'b1);
    doRead(18'h12344);
    doRead(18'h12345);

    // Random write then read-back, including back-to-back direction changes
    for (int i = 0; i < 40; i++) begin
      logic [17:0] a;
      logic [3:0] d;
      a = 18'($urandom);
      d = 4'($urandom);
      doWrite(a, d, 1'b0);
      doRead(a);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule